// File: doc/BRIEF.md
# Dithered Current-Mode PWM Generator

This block is the digital timing core of a peak-current-mode flyback controller. From a 100 MHz system clock it derives the switching period, raises the gate-enable pulse at the start of each period and drops it when the first of three things happens. These are a current-sense comparator trip once the blanking window has passed, the 75% duty ceiling, or a drop of the enable input. Analog comparators, slope compensation and the gate driver sit outside the block.

To spread conducted EMI, the period is not fixed. A triangular counter moves one step per switching cycle. Its value, scaled by 1.25, is added to a base count, so the frequency sweeps about ±4 kHz around 65 kHz. A full triangle takes roughly 296 cycles, which is about 220 Hz. A light-load controller can ask for a longer period through a floor input, and the longer of the two periods is used. The period count is fixed at each cycle start.

Top module: `pwm_dither_core`

## Requirements
- R1: While `rst` is high, `gate_on` and `cyc_start` are low. On the first clock edge with `rst` low, a cycle starts: `cyc_start` is high for that clock, and `gate_on` is high if `sw_en` is high.
- R2: With base B = NOM_PERIOD − (DITH_HALF + ⌊DITH_HALF/4⌋) and dither value d, a cycle lasts max(B + d + ⌊d/4⌋, `floor_period`) clocks. Both d and `floor_period` are taken at the clock edge that starts the cycle.
- R3: After reset, d is 0 for the first cycle. It then rises by one per cycle to 2·DITH_HALF, falls by one per cycle to 0, and repeats this triangle.
- R4: `cyc_start` is high for exactly the first clock of every cycle and low at all other times.
- R5: `gate_on` rises only on the first clock of a cycle, and only if `sw_en` is high at the edge that starts the cycle.
- R6: In a cycle of P clocks, `gate_on` is high for at most ⌊3P/4⌋ clocks, counted from the cycle's first clock.
- R7: A high `cs_trip` has no effect while the gate is in clock positions 0 to BLANK_CLK−1 of a cycle.
- R8: If `cs_trip` is high in clock position BLANK_CLK or later while the gate is high, `gate_on` is low from the next clock to the end of that cycle.
- R9: If `sw_en` is low at a clock edge, `gate_on` is low after that edge. The gate stays low until a cycle starts with `sw_en` high.
- R10: A `floor_period` value below the dithered period does not change the cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| sw_en | input | 1 | Switching enable; low forces the gate off |
| cs_trip | input | 1 | Current-sense comparator flag, high when the peak is reached |
| floor_period | input | CNT_W | Minimum period in clocks requested by the light-load controller; 0 means no request |
| gate_on | output | 1 | Gate-drive enable pulse |
| cyc_start | output | 1 | One-clock strobe on the first clock of each switching cycle |

## Verification
On every clock, the in-line properties check the following. The gate rises only together with the cycle strobe. It never stays on past the duty ceiling. It falls one clock after a trip outside blanking or a low enable, and it holds through a trip inside blanking. They also check that the dither value stays in range and moves by exactly one per cycle, and that the period count never reaches its own limit. Only the bench scenarios can show that the cycle lengths follow the full triangle, including its turnarounds. The same holds for a floor request lengthening the period or leaving it untouched, and for the first pulse arriving on the first clock after reset. The bench covers these by comparing the outputs with a behavioural model on every clock.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] per_t;

    typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

    typedef struct packed {
        per_t cnt;
        per_t per;
        logic tick;
    } tmr_s;

    // dither value scaled by 1.25
    function automatic per_t dscale(input per_t d);
        return d + (d >> 2);
    endfunction

    // floor(3*p/4) without overflow
    function automatic per_t duty_cap(input per_t p);
        logic [CNT_W+1:0] t;
        t = {2'b00, p} + {1'b0, p, 1'b0};
        t = t >> 2;
        return t[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pwm_dither_tri.sv
module pwm_dither_tri
    import pwm_dither_pkg::*;
#(
    parameter int DITH_HALF = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output per_t d
);
    localparam per_t TOP = per_t'(2 * DITH_HALF);

    dir_e dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            d   <= '0;
            dir <= DIR_UP;
        end else if (step) begin
            if (dir == DIR_UP) begin
                if (d == TOP) begin
                    dir <= DIR_DN;
                    d   <= d - 1'b1;
                end else begin
                    d <= d + 1'b1;
                end
            end else begin
                if (d == '0) begin
                    dir <= DIR_UP;
                    d   <= per_t'(1);
                end else begin
                    d <= d - 1'b1;
                end
            end
        end
    end

    p_range_r3: assert property (@(posedge clk) disable iff (rst) d <= TOP);
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        step |=> (d == $past(d) + 1'b1) || (d == $past(d) - 1'b1));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(d));

endmodule

// File: rtl/pwm_period_tmr.sv
module pwm_period_tmr
    import pwm_dither_pkg::*;
#(
    parameter int NOM_PERIOD = 1538,
    parameter int DITH_HALF  = 74
) (
    input  logic clk,
    input  logic rst,
    input  per_t d,
    input  per_t floor_period,
    output tmr_s tmr
);
    localparam per_t BASE = per_t'(NOM_PERIOD - DITH_HALF - DITH_HALF / 4);

    per_t cnt, per, dith_per, per_next;
    logic tick;

    always_comb begin
        tick     = (cnt == per - 1'b1);
        dith_per = BASE + dscale(d);
        per_next = (floor_period > dith_per) ? floor_period : dith_per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= BASE - 1'b1;
            per <= BASE;
        end else if (tick) begin
            cnt <= '0;
            per <= per_next;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tmr = '{cnt: cnt, per: per, tick: tick};

    p_cnt_in_r2: assert property (@(posedge clk) disable iff (rst) cnt < per);
    p_floor_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> per >= $past(floor_period));
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == '0);

endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl
    import pwm_dither_pkg::*;
#(
    parameter int BLANK_CLK = 25
) (
    input  logic clk,
    input  logic rst,
    input  tmr_s tmr,
    input  logic en,
    input  logic trip,
    output logic gate,
    output logic strobe
);
    localparam per_t BLANK = per_t'(BLANK_CLK);

    per_t cap, nxt;
    logic trip_live;

    always_comb begin
        cap       = duty_cap(tmr.per);
        nxt       = tmr.cnt + 1'b1;
        trip_live = trip && (tmr.cnt >= BLANK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= tmr.tick;
            if (tmr.tick)
                gate <= en;
            else if (!en || (nxt >= cap) || trip_live)
                gate <= 1'b0;
        end
    end

    p_cap_r6: assert property (@(posedge clk) disable iff (rst)
        gate |-> tmr.cnt < cap);
    p_en_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate);
    p_trip_end_r8: assert property (@(posedge clk) disable iff (rst)
        (gate && trip && tmr.cnt >= BLANK && !tmr.tick) |=> !gate);
    p_blank_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (gate && en && !tmr.tick && nxt < cap && tmr.cnt < BLANK) |=> gate);

endmodule

// File: rtl/pwm_dither_core.sv
module pwm_dither_core
    import pwm_dither_pkg::*;
#(
    parameter int NOM_PERIOD = 1538,
    parameter int DITH_HALF  = 74,
    parameter int BLANK_CLK  = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_en,
    input  logic             cs_trip,
    input  logic [CNT_W-1:0] floor_period,
    output logic             gate_on,
    output logic             cyc_start
);
    per_t d;
    tmr_s tmr;

    pwm_dither_tri #(.DITH_HALF(DITH_HALF)) u_tri (
        .clk  (clk),
        .rst  (rst),
        .step (tmr.tick),
        .d    (d)
    );

    pwm_period_tmr #(.NOM_PERIOD(NOM_PERIOD), .DITH_HALF(DITH_HALF)) u_tmr (
        .clk          (clk),
        .rst          (rst),
        .d            (d),
        .floor_period (floor_period),
        .tmr          (tmr)
    );

    pwm_gate_ctl #(.BLANK_CLK(BLANK_CLK)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .tmr    (tmr),
        .en     (sw_en),
        .trip   (cs_trip),
        .gate   (gate_on),
        .strobe (cyc_start)
    );

    p_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> cyc_start);
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !cyc_start);

endmodule

// File: tb/test_pwm_dither_core.sv
module test_pwm_dither_core;
    localparam int NOM  = 40;
    localparam int HALF = 4;
    localparam int BLK  = 5;
    localparam int BASE = NOM - HALF - HALF / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_en = 1'b1;
    logic        cs_trip = 1'b0;
    logic [15:0] floor_period = '0;
    logic        gate_on, cyc_start;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pwm_dither_core #(.NOM_PERIOD(NOM), .DITH_HALF(HALF), .BLANK_CLK(BLK)) i_pwm_dither_core (
        .clk          (clk),
        .rst          (rst),
        .sw_en        (sw_en),
        .cs_trip      (cs_trip),
        .floor_period (floor_period),
        .gate_on      (gate_on),
        .cyc_start    (cyc_start)
    );

    // behavioural reference model
    int    pos, per_m, dv;
    bit    up, first, gate_m, strobe_m;
    string gtag = "R1";
    string stag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            pos = BASE - 1; per_m = BASE; dv = 0; up = 1; first = 1;
            gate_m = 0; strobe_m = 0; gtag = "R1"; stag = "R1";
        end else if (pos == per_m - 1) begin
            int dp;
            dp = BASE + dv + dv / 4;
            if (first) stag = "R1";
            else if (int'(floor_period) > dp) stag = "R2";
            else if (floor_period != 0) stag = "R10";
            else stag = "R3";
            per_m = (int'(floor_period) > dp) ? int'(floor_period) : dp;
            if (up) begin
                if (dv == 2 * HALF) begin up = 0; dv = dv - 1; end
                else dv = dv + 1;
            end else begin
                if (dv == 0) begin up = 1; dv = 1; end
                else dv = dv - 1;
            end
            first = 0; pos = 0; strobe_m = 1;
            gate_m = sw_en; gtag = first ? "R1" : "R5";
        end else begin
            int c;
            c = pos; pos = pos + 1; strobe_m = 0; stag = "R4";
            if (gate_m) begin
                if (!sw_en) begin gate_m = 0; gtag = "R9"; end
                else if (pos >= per_m * 3 / 4) begin gate_m = 0; gtag = "R6"; end
                else if (cs_trip && c >= BLK) begin gate_m = 0; gtag = "R8"; end
                else if (cs_trip) gtag = "R7";
            end else if (gtag == "R5" || gtag == "R1") gtag = "R9";
        end
    end

    task automatic compare();
        checks++;
        if (gate_on !== gate_m) begin
            errors++;
            $display("FAIL %s gate_on: actual=%b expected=%b at %0t", gtag, gate_on, gate_m, $time);
        end
        checks++;
        if (cyc_start !== strobe_m) begin
            errors++;
            $display("FAIL %s cyc_start: actual=%b expected=%b at %0t", stag, cyc_start, strobe_m, $time);
        end
    endtask

    int unsigned seed = 32'h1234_5678;
    function automatic bit rnd(input int unsigned mod);
        seed = seed * 1103515245 + 12345;
        return ((seed >> 16) % mod) == 0;
    endfunction

    task automatic run(input int n, input int mode, input int fl);
        floor_period = 16'(fl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            case (mode)
                0: begin sw_en = 1; cs_trip = 0; end
                1: begin sw_en = 1; cs_trip = rnd(3); end
                2: begin sw_en = 1; cs_trip = 1; end
                default: begin sw_en = !rnd(6); cs_trip = rnd(4); end
            endcase
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (gate_on !== 1'b0 || cyc_start !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual=%b%b expected=00", gate_on, cyc_start);
        end
        rst = 0;
        run(700, 0, 0);    // R2 R3 R6: duty cap across a full triangle
        run(400, 1, 0);    // R7 R8: random trips
        run(300, 2, 0);    // R7 R8: trip held high
        run(300, 0, 60);   // R2: floor lengthens period
        run(300, 0, 20);   // R10: small floor ignored
        run(600, 3, 0);    // R9 R5: enable drops mid-pulse
        finish_up();
    end
endmodule